// File: doc/BRIEF.md
# Post-Scaled Luminance Quantizer

This block quantizes a serial stream of scaled two-dimensional DCT coefficients, one coefficient per clock, 64 per 8x8 block. The transform that feeds it leaves every coefficient short of its true value by a per-position scale factor. Here that scale factor, the reciprocal of the luminance quantization step and a gain of 4096 are folded into a single integer held in a 64-entry constant table. Quantization therefore costs one multiply, one rounding shift and one saturation. There is no divider and no separate scaling stage.

A start-of-block flag marks coefficient 0 of each block. An internal position counter addresses the table in row-major order, where position = 8*row + column, and labels each result. The table is built at elaboration from two parameters: a post-scale vector and a luminance step table. Only luminance steps are used because the input is grayscale.

Top module: `lum_quantizer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` and `out_sof` are 0.
- R2: A coefficient accepted with `in_valid`=1 at a rising edge produces `out_valid`=1 exactly two rising edges later, with `out_sof` equal to the `in_sof` it carried. Cycles with `in_valid`=0 produce `out_valid`=0 two edges later.
- R3: The position of an accepted coefficient is 0 when its `in_sof` is 1. Otherwise it is the position of the previous accepted coefficient plus one, modulo 64. Idle cycles leave the count unchanged. The position is reported on `out_pos`.
- R4: A start-of-block flag arriving before position 63 is reached restarts the count at 0 for that coefficient.
- R5: The factor for position p = 8*i + j is round(s[i]*s[j]*4096/Q[p]). Here s[k] = S[k]/65536, with S = {23170, 16705, 17734, 19705, 23170, 29490, 42814, 83981}. Q is the row-major luminance table whose rows are {16,11,10,16,24,40,51,61}, {12,12,14,19,26,58,60,55}, {14,13,16,24,40,57,69,56}, {14,17,22,29,51,87,80,62}, {18,22,37,56,68,109,103,77}, {24,35,55,64,81,104,113,92}, {49,64,78,87,103,121,120,101} and {72,92,95,98,112,100,103,99}.
- R6: `out_q` equals the product of the 18-bit signed coefficient and its factor, divided by 4096 and rounded to nearest, with exact halves rounded away from zero.
- R7: Results above 1023 are clamped to 1023, and results below -1024 are clamped to -1024 (11-bit signed).
- R8: A zero coefficient yields 0, and a non-negative coefficient never yields a negative result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Coefficient on `in_coef` is present |
| in_sof | input | 1 | Coefficient is position 0 of a new block |
| in_coef | input | 18 | Scaled DCT coefficient, two's complement |
| out_valid | output | 1 | Result on `out_q` is present |
| out_sof | output | 1 | Result is position 0 of a block |
| out_pos | output | 6 | Row-major position of the result within its block |
| out_q | output | 11 | Quantized coefficient, two's complement |

## Verification
Each result, including its valid flag, start flag and position, is due on the second rising edge after the coefficient is accepted. The reference model keeps a two-deep shift of expected results, advanced once per rising edge. Outputs are compared against its older entry at the following falling edge, every cycle, idle cycles included. Stimulus covers ramps, idle gaps, a mid-block restart, a run past position 63, exact-half products at position 0 and extremes that force clamping.

// File: rtl/lum_quantizer.sv
module lum_quantizer #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 11,
  parameter int FW    = 16,
  parameter int GAIN  = 12,
  parameter int SFRAC = 16,
  parameter int unsigned SPOST [8] = '{23170, 16705, 17734, 19705, 23170, 29490, 42814, 83981},
  parameter int unsigned QLUM [64] = '{
    16, 11, 10, 16, 24, 40, 51, 61,
    12, 12, 14, 19, 26, 58, 60, 55,
    14, 13, 16, 24, 40, 57, 69, 56,
    14, 17, 22, 29, 51, 87, 80, 62,
    18, 22, 37, 56, 68,109,103, 77,
    24, 35, 55, 64, 81,104,113, 92,
    49, 64, 78, 87,103,121,120,101,
    72, 92, 95, 98,112,100,103, 99}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic signed [IN_W-1:0]  in_coef,
  output logic                    out_valid,
  output logic                    out_sof,
  output logic [5:0]              out_pos,
  output logic signed [OUT_W-1:0] out_q
);
  localparam int PW    = IN_W + FW + 1;
  localparam int SHIFT = 2*SFRAC - GAIN;
  localparam longint POS_LIM = (64'sd1 <<< (OUT_W-1)) - 1;
  localparam longint NEG_LIM = (64'sd1 <<< (OUT_W-1));

  function automatic logic [FW-1:0] factor_of(input int p);
    longint num, den;
    num = longint'(SPOST[p/8]) * longint'(SPOST[p%8]);
    den = longint'(QLUM[p]) <<< SHIFT;
    return FW'((num + den/2) / den);
  endfunction

  logic [FW-1:0] rom [64];
  for (genvar g = 0; g < 64; g++) begin : g_rom
    assign rom[g] = factor_of(g);
  end

  logic [5:0] cnt;
  wire  [5:0] pos_now = in_sof ? 6'd0 : cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (in_valid) cnt <= pos_now + 6'd1;

  logic                 s1_valid, s1_sof;
  logic [5:0]           s1_pos;
  logic signed [PW-1:0] s1_prod;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sof   <= 1'b0;
      s1_pos   <= '0;
      s1_prod  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_sof   <= in_valid & in_sof;
      s1_pos   <= pos_now;
      s1_prod  <= PW'(in_coef) * $signed({1'b0, rom[pos_now]});
    end

  logic              neg;
  logic [PW-1:0]     mag, rnd;
  logic signed [OUT_W-1:0] sat;

  always_comb begin
    neg = s1_prod[PW-1];
    mag = neg ? PW'(-s1_prod) : PW'(s1_prod);
    rnd = (mag + (PW'(1) << (GAIN-1))) >> GAIN;
    if (!neg) sat = (rnd > PW'(POS_LIM)) ? OUT_W'(POS_LIM) : OUT_W'(rnd);
    else      sat = (rnd > PW'(NEG_LIM)) ? OUT_W'(-NEG_LIM) : OUT_W'(-rnd);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_pos   <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= s1_valid;
      out_sof   <= s1_sof;
      out_pos   <= s1_pos;
      out_q     <= sat;
    end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid); // R2
  AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid); // R2
  AST_SOF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R2
  AST_SOF_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |-> ##2 (out_sof && out_pos == 6'd0)); // R4
  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_coef == '0) |-> ##2 (out_q == '0)); // R8
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_coef[IN_W-1]) |-> ##2 !out_q[OUT_W-1]); // R8
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof) |=> (s1_pos == $past(cnt))); // R3
endmodule

// File: tb/tb_lum_quantizer.sv
module tb_lum_quantizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic signed [17:0] in_coef = '0;
  logic out_valid, out_sof;
  logic [5:0] out_pos;
  logic signed [10:0] out_q;

  always #2 clk = ~clk;

  lum_quantizer dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_coef(in_coef), .out_valid(out_valid), .out_sof(out_sof), .out_pos(out_pos), .out_q(out_q));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int S [8] = '{23170, 16705, 17734, 19705, 23170, 29490, 42814, 83981};
  int Q [64] = '{16,11,10,16,24,40,51,61, 12,12,14,19,26,58,60,55,
                 14,13,16,24,40,57,69,56, 14,17,22,29,51,87,80,62,
                 18,22,37,56,68,109,103,77, 24,35,55,64,81,104,113,92,
                 49,64,78,87,103,121,120,101, 72,92,95,98,112,100,103,99};

  int cnt = 0;
  bit ev1 = 0, ev2 = 0, es1 = 0, es2 = 0;
  int ep1 = 0, ep2 = 0, eq1 = 0, eq2 = 0;
  string et1 = "R6", et2 = "R6";

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int factor(int p);
    real v;
    v = (real'(S[p/8]) / 65536.0) * (real'(S[p%8]) / 65536.0) * 4096.0 / real'(Q[p]);
    return $rtoi(v + 0.5);
  endfunction

  task automatic step(bit v, bit s, int x);
    int p;
    longint prod, m, r, lim;
    in_valid = v; in_sof = s; in_coef = x[17:0];
    @(posedge clk);
    ev2 = ev1; es2 = es1; ep2 = ep1; eq2 = eq1; et2 = et1;
    ev1 = v; es1 = v && s;
    if (v) begin
      p = s ? 0 : cnt;
      cnt = (p + 1) % 64;
      prod = longint'(x) * factor(p);
      m = prod < 0 ? -prod : prod;
      r = (m + 2048) / 4096;
      lim = prod < 0 ? 1024 : 1023;
      et1 = (x == 0) ? "R8" : (r > lim ? "R7" : "R6");
      if (r > lim) r = lim;
      ep1 = p;
      eq1 = int'(prod < 0 ? -r : r);
    end
    @(negedge clk);
    check("R2 valid", out_valid, ev2);
    if (ev2) begin
      check("R2 sof", out_sof, es2);
      check("R3 pos", out_pos, ep2);
      check({et2, " value"}, out_q, eq2);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", out_valid, 0);
    check("R1 sof in reset", out_sof, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", out_valid, 0);
    check("R1 sof after reset", out_sof, 0);
    // R5 R6: ramp block
    for (int i = 0; i < 64; i++) step(1, i == 0, i * 1013 - 30000);
    // R3: idle gaps hold the count
    for (int i = 0; i < 80; i++) step((i % 5) != 3, i == 0, (i * 7919) % 131072 - 65536);
    // R4: mid-block restart
    for (int i = 0; i < 40; i++) step(1, i == 0 || i == 21, 500 * (i - 20));
    // R3: run past position 63 wraps to 0
    for (int i = 0; i < 70; i++) step(1, i == 0, -i * 321);
    // R6 R7 R8: position 0 halves and extremes
    step(1, 1, 64);     step(1, 1, -64);   step(1, 1, 63);
    step(1, 1, -63);    step(1, 1, 131071); step(1, 1, -131072);
    step(1, 1, 0);
    // R7: large magnitudes at every position
    for (int i = 0; i < 64; i++) step(1, i == 0, (i % 2) ? -131072 : 131071);
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule